// File: doc/BRIEF.md
# Line-Locked Pixel Counter with Toggle Pulse Lanes

This block keeps the horizontal position of an image-sensor timing generator. A 13-bit pixel counter advances once per clock and is pulled back to zero a fixed number of clocks after each falling edge of an external active-low horizontal-drive strobe. The strobe and its vertical companion are each brought in through a two-flop synchronizer before any edge is recognised. Until a strobe arrives, the counter climbs and then holds at its top value.

A set of pulse lanes is driven from the counter. These lanes produce the blanking, clamp, vertical-transfer and substrate-clear waveforms. Each lane has two programmed positions. The lane inverts whenever the counter steps onto either position. At every counter reset the lane falls back to a programmable start level.

Toggles that would land in the stretch of counts just before a pending counter reset are suppressed and reported through a sticky flag. A position of zero on the lanes that carry vertical transfer and substrate clear is also suppressed and reported. A strobe ordering fault, where the horizontal edge arrives one clock ahead of the vertical edge, raises a third sticky flag. Every pin is a plain level signal with no handshake. The block never stalls, and nothing upstream or downstream can hold it back.

Top module: `hd_line_timer`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pix_cnt` becomes 0, `pulse_out` becomes `start_pol`, and `guard_err`, `zero_err` and `seq_err` become 0.
- R2: Without a counter reset, `pix_cnt` rises by exactly one on every rising edge. It stops at 8191 (all ones) and stays there.
- R3: Call E1 the first rising edge that samples `hd_n` low after it was sampled high on two earlier edges. `pix_cnt` becomes 0 on the 36th rising edge counting E1 as the first.
- R4: Lane k inverts on the edge where `pix_cnt` takes the value in bits [13k+12:13k] of `tog1_pos` or of `tog2_pos`. When both positions are equal the lane inverts once. A lane does not invert again while the counter holds at 8191.
- R5: On the edge where the counter is reset by the strobe, every lane loads its `start_pol` bit. The only exception is a permitted zero toggle, which is covered by R7.
- R6: A toggle match on any count the counter takes from E2 through E35 (numbered as in R3) is suppressed and sets `guard_err`. The same position outside that stretch toggles normally. `guard_err` stays set until reset.
- R7: Lanes 0 and 1 (vertical transfer, substrate clear) never toggle at position 0. Such a match sets the sticky `zero_err`. The other lanes with position 0 load the inverse of their start level on the reset edge.
- R8: `seq_err` is set, and stays set, when `hd_n` is first sampled low exactly one rising edge before `vd_n` is first sampled low. Edges sampled on the same rising edge, or with `hd_n` later, leave it clear.
- R9: A lane programmed with position P changes on the (P+36)th rising edge counting E1 as the first. To obtain an edge D clocks into the line, write D-36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hd_n | input | 1 | External horizontal strobe, active low, asynchronous |
| vd_n | input | 1 | External vertical strobe, active low, asynchronous |
| tog1_pos | input | 78 | First toggle position per lane, 13 bits each, lane k at bits [13k+12:13k] |
| tog2_pos | input | 78 | Second toggle position per lane, same packing |
| start_pol | input | 6 | Level each lane loads at reset and at every counter reset |
| pix_cnt | output | 13 | Current pixel count |
| pulse_out | output | 6 | Lane outputs; 0 vertical transfer, 1 substrate clear, 2..5 blanking and clamp |
| guard_err | output | 1 | Sticky: a toggle fell in the pre-reset stretch |
| zero_err | output | 1 | Sticky: position 0 used on lane 0 or 1 |
| seq_err | output | 1 | Sticky: horizontal edge one clock ahead of vertical edge |

## Verification
Several properties are checked by assertions on every cycle:
- the counter's single-step and saturation rule, and that it reaches zero only through the strobe path;
- that lanes hold still throughout the pre-reset stretch;
- that the banned lanes sit at their start level right after a counter reset;
- that all three flags are sticky.

The exact latency from the strobe to the counter reset, the placement of a programmed edge relative to the strobe, and the ordering rule between the two strobes are timing relations across dozens of clocks. Only the bench's scenarios show those. The same holds for the single flip on equal positions and for lane levels over whole random lines.

// File: rtl/hdlt_pkg.sv
package hdlt_pkg;

  // Per-edge events the counter hands to every pulse lane.
  typedef struct packed {
    logic reload;    // counter takes 0 on this edge because of the strobe
    logic pend_win;  // this edge lies in the stretch ahead of a pending reset
    logic hold;      // counter is saturated and does not move on this edge
  } line_ev_t;

endpackage

// File: rtl/hdlt_fall_sync.sv
module hdlt_fall_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= pin_n;
      s2_q <= s1_q;
    end
  end

  // High for one cycle after the low level has passed both flops' inputs.
  assign fall = s2_q & ~s1_q;
endmodule

// File: rtl/hdlt_line_ctr.sv
module hdlt_line_ctr
  import hdlt_pkg::*;
#(
  parameter int CNT_W   = 13,
  parameter int RST_LAT = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hd_fall,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nx,
  output line_ev_t         ev
);
  localparam int               DW   = $clog2(RST_LAT);
  // hd_fall is seen one edge after E1; reset lands on edge E1+RST_LAT-1.
  localparam logic [DW-1:0]    LOAD = DW'(RST_LAT - 3);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [DW-1:0] dly_q;
  logic          armed_q;

  always_comb begin
    ev.reload   = armed_q && (dly_q == '0) && !hd_fall;
    ev.pend_win = hd_fall || (armed_q && (dly_q != '0));
    ev.hold     = (cnt == CMAX) && !ev.reload;
    if (ev.reload)      cnt_nx = '0;
    else if (ev.hold)   cnt_nx = CMAX;
    else                cnt_nx = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_q   <= '0;
      armed_q <= 1'b0;
      cnt     <= '0;
    end else begin
      cnt <= cnt_nx;
      if (hd_fall) begin
        armed_q <= 1'b1;
        dly_q   <= LOAD;
      end else if (armed_q) begin
        if (dly_q == '0) armed_q <= 1'b0;
        else             dly_q   <= dly_q - DW'(1);
      end
    end
  end
endmodule

// File: rtl/hdlt_lane.sv
module hdlt_lane
  import hdlt_pkg::*;
#(
  parameter int CNT_W    = 13,
  parameter bit ZERO_BAN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pos_a,
  input  logic [CNT_W-1:0] pos_b,
  input  logic [CNT_W-1:0] cnt_nx,
  input  line_ev_t         ev,
  output logic             q,
  output logic             guard_hit,
  output logic             zero_hit
);
  logic hit, q_nx;

  always_comb begin
    hit       = !ev.hold && ((cnt_nx == pos_a) || (cnt_nx == pos_b));
    guard_hit = hit && ev.pend_win;
    zero_hit  = hit && ev.reload && ZERO_BAN;
    if (ev.reload)
      q_nx = start ^ (hit && !ZERO_BAN);
    else if (hit && !ev.pend_win)
      q_nx = ~q;
    else
      q_nx = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= start;
    else        q <= q_nx;
  end
endmodule

// File: rtl/hd_line_timer.sv
module hd_line_timer
  import hdlt_pkg::*;
#(
  parameter int               CNT_W         = 13,
  parameter int               NUM_CH        = 6,
  parameter int               RST_LAT       = 36,
  parameter logic [NUM_CH-1:0] ZERO_BAN_MASK = NUM_CH'(3)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hd_n,
  input  logic                    vd_n,
  input  logic [NUM_CH*CNT_W-1:0] tog1_pos,
  input  logic [NUM_CH*CNT_W-1:0] tog2_pos,
  input  logic [NUM_CH-1:0]       start_pol,
  output logic [CNT_W-1:0]        pix_cnt,
  output logic [NUM_CH-1:0]       pulse_out,
  output logic                    guard_err,
  output logic                    zero_err,
  output logic                    seq_err
);
  logic             hd_fall, vd_fall, hd_fall_q;
  logic [CNT_W-1:0] cnt_nx;
  line_ev_t         line_ev;
  logic [NUM_CH-1:0] lane_guard, lane_zero;

  hdlt_fall_sync u_hd_sync (.clk(clk), .rst_n(rst_n), .pin_n(hd_n), .fall(hd_fall));
  hdlt_fall_sync u_vd_sync (.clk(clk), .rst_n(rst_n), .pin_n(vd_n), .fall(vd_fall));

  hdlt_line_ctr #(.CNT_W(CNT_W), .RST_LAT(RST_LAT)) u_ctr (
    .clk(clk), .rst_n(rst_n), .hd_fall(hd_fall),
    .cnt(pix_cnt), .cnt_nx(cnt_nx), .ev(line_ev)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    hdlt_lane #(.CNT_W(CNT_W), .ZERO_BAN(ZERO_BAN_MASK[g])) u_lane (
      .clk(clk), .rst_n(rst_n), .start(start_pol[g]),
      .pos_a(tog1_pos[g*CNT_W +: CNT_W]), .pos_b(tog2_pos[g*CNT_W +: CNT_W]),
      .cnt_nx(cnt_nx), .ev(line_ev),
      .q(pulse_out[g]), .guard_hit(lane_guard[g]), .zero_hit(lane_zero[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd_fall_q <= 1'b0;
      guard_err <= 1'b0;
      zero_err  <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      hd_fall_q <= hd_fall;
      guard_err <= guard_err | (|lane_guard);
      zero_err  <= zero_err  | (|lane_zero);
      seq_err   <= seq_err   | (hd_fall_q & vd_fall);
    end
  end
endmodule

// File: rtl/hd_line_timer_chk.sv
module hd_line_timer_chk #(
  parameter int               CNT_W         = 13,
  parameter int               NUM_CH        = 6,
  parameter logic [NUM_CH-1:0] ZERO_BAN_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  pix_cnt,
  input logic [NUM_CH-1:0] pulse_out,
  input logic [NUM_CH-1:0] start_pol,
  input logic              guard_err,
  input logic              zero_err,
  input logic              seq_err,
  input logic              reload,
  input logic              pend_win
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt != CMAX) |=> (pix_cnt == $past(pix_cnt) + CNT_W'(1)) || (pix_cnt == '0));

  a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt == CMAX) |=> (pix_cnt == CMAX) || (pix_cnt == '0));

  a_r3_zero_only_by_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && pix_cnt != CMAX) |=> (pix_cnt != '0));

  a_r6_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pend_win |=> $stable(pulse_out));

  a_r7_banned_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (((pulse_out ^ $past(start_pol)) & ZERO_BAN_MASK) == '0));

  a_r6_guard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    guard_err |=> guard_err);

  a_r7_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    zero_err |=> zero_err);

  a_r8_seq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
endmodule

bind hd_line_timer hd_line_timer_chk #(
  .CNT_W(CNT_W), .NUM_CH(NUM_CH), .ZERO_BAN_MASK(ZERO_BAN_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .pulse_out(pulse_out),
  .start_pol(start_pol), .guard_err(guard_err), .zero_err(zero_err),
  .seq_err(seq_err), .reload(line_ev.reload), .pend_win(line_ev.pend_win)
);

// File: tb/hd_line_timer_tb.sv
module hd_line_timer_tb;
  localparam int CW = 13;
  localparam int NC = 6;
  localparam int UNUSED = 8191;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd_n = 1'b1, vd_n = 1'b1;
  logic [NC*CW-1:0] tog1 = '1, tog2 = '1;
  logic [NC-1:0] st = 6'b101010;
  logic [CW-1:0] pix_cnt;
  logic [NC-1:0] pulse_out;
  logic guard_err, zero_err, seq_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hd_line_timer u_dut (
    .clk(clk), .rst_n(rst_n), .hd_n(hd_n), .vd_n(vd_n),
    .tog1_pos(tog1), .tog2_pos(tog2), .start_pol(st),
    .pix_cnt(pix_cnt), .pulse_out(pulse_out),
    .guard_err(guard_err), .zero_err(zero_err), .seq_err(seq_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_lvl(logic s, int t1, int t2, int c);
    logic v;
    v = s;
    if (t1 <= c) v = ~v;
    if (t2 <= c && t2 != t1) v = ~v;
    return v;
  endfunction

  task automatic set_tog(input int ch, input int a, input int b);
    tog1[ch*CW +: CW] = CW'(a);
    tog2[ch*CW +: CW] = CW'(b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hd_n = 1'b1; vd_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pix_cnt == 0, "R1 cnt", pix_cnt, 0);
    chk(pulse_out == st, "R1 pulse", pulse_out, st);
    chk({guard_err, zero_err, seq_err} == 3'b000, "R1 flags",
        {guard_err, zero_err, seq_err}, 0);
    rst_n = 1'b1;

    // R2 and R4: free count to saturation; all positions at 8191 flip once
    for (int k = 1; k <= 8200; k++) begin
      @(negedge clk);
      chk(pix_cnt == CW'((k > UNUSED) ? UNUSED : k), "R2 count", pix_cnt,
          (k > UNUSED) ? UNUSED : k);
      for (int c = 0; c < NC; c++)
        chk(pulse_out[c] == exp_lvl(st[c], UNUSED, UNUSED, int'(pix_cnt)),
            "R4 single flip at 8191", pulse_out[c], exp_lvl(st[c], UNUSED, UNUSED, int'(pix_cnt)));
    end

    // R3 R5 R7 R9 R4 R6: one strobe at i=0, another at i=200
    set_tog(0, 0, UNUSED);
    set_tog(1, 5, UNUSED);
    set_tog(2, 0, UNUSED);
    set_tog(3, 24, 30);
    set_tog(4, 10, 10);
    set_tog(5, UNUSED, UNUSED);
    hd_n = 1'b0;
    for (int i = 1; i <= 450; i++) begin
      @(negedge clk);
      if (i == 35) chk(pix_cnt != 0, "R3 not yet", pix_cnt, UNUSED);
      if (i == 36) begin
        chk(pix_cnt == 0, "R3 reset edge", pix_cnt, 0);
        chk(zero_err == 1'b1, "R7 zero flag", zero_err, 1);
        chk(pulse_out[0] == st[0], "R7 banned lane", pulse_out[0], st[0]);
        chk(pulse_out[2] == ~st[2], "R7 allowed zero", pulse_out[2], ~st[2]);
        chk(pulse_out[5:3] == st[5:3] && pulse_out[1] == st[1], "R5 reload",
            pulse_out, st);
        chk(guard_err == 1'b0, "R6 no spurious guard", guard_err, 0);
      end
      if (i == 59) chk(pulse_out[3] == st[3], "R9 before", pulse_out[3], st[3]);
      if (i == 60) chk(pulse_out[3] == ~st[3], "R9 at 24+36", pulse_out[3], ~st[3]);
      if (i == 66) chk(pulse_out[3] == st[3], "R4 second position", pulse_out[3], st[3]);
      if (i == 50) chk(pulse_out[4] == ~st[4], "R4 equal positions", pulse_out[4], ~st[4]);
      if (i == 100) set_tog(1, 190, UNUSED);
      if (i == 220) chk(guard_err == 1'b0, "R6 before window", guard_err, 0);
      if (i == 230) begin
        chk(guard_err == 1'b1, "R6 guard flag", guard_err, 1);
        chk(pulse_out[1] == ~st[1], "R6 suppressed", pulse_out[1], ~st[1]);
      end
      if (i == 425) chk(pulse_out[1] == st[1], "R6 after reload", pulse_out[1], st[1]);
      if (i == 427) chk(pulse_out[1] == ~st[1], "R6 outside window", pulse_out[1], ~st[1]);
      if (i == 440) chk(guard_err == 1'b1, "R6 sticky", guard_err, 1);
      hd_n = (i >= 200 && i <= 202) || i <= 2 ? 1'b0 : 1'b1;
    end

    // R8: ordering of strobes
    do_reset();
    @(negedge clk); hd_n = 1'b0;
    @(negedge clk); vd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(seq_err == 1'b1, "R8 early hd", seq_err, 1);
    repeat (5) @(negedge clk);
    chk(seq_err == 1'b1, "R8 sticky", seq_err, 1);
    do_reset();
    @(negedge clk); hd_n = 1'b0; vd_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(seq_err == 1'b0, "R8 same edge", seq_err, 0);
    do_reset();
    @(negedge clk); vd_n = 1'b0;
    @(negedge clk); hd_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(seq_err == 1'b0, "R8 hd later", seq_err, 0);

    // Random lines: R3 R4 R5 R9
    void'($urandom(32'd20240611));
    for (int b = 0; b < 4; b++) begin
      int per;
      int p1[NC], p2[NC];
      per = int'($urandom_range(600, 120));
      st = NC'($urandom);
      do_reset();
      for (int ln = 0; ln < 6; ln++) begin
        for (int i = 0; i < per; i++) begin
          if (i >= 36) begin
            chk(pix_cnt == CW'(i - 36), "R3 line count", pix_cnt, i - 36);
            for (int c = 0; c < NC; c++)
              chk(pulse_out[c] == exp_lvl(st[c], p1[c], p2[c], i - 36),
                  "R4 random lane", pulse_out[c], exp_lvl(st[c], p1[c], p2[c], i - 36));
          end
          if (i == 10) begin
            for (int c = 0; c < NC; c++) begin
              p1[c] = int'($urandom_range(per - 40, (c < 2) ? 1 : 0));
              p2[c] = ($urandom_range(3, 0) == 0) ? p1[c]
                      : int'($urandom_range(per - 40, (c < 2) ? 1 : 0));
              set_tog(c, p1[c], p2[c]);
            end
          end
          hd_n = (i <= 2) ? 1'b0 : 1'b1;
          @(negedge clk);
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule